// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending-bit array of an MSI-X capable function. Software programs each vector's 64-bit message address, 32-bit message data and a per-vector mask through 32-bit register accesses. It controls the whole function through one control byte that carries an enable bit and a mask-all bit. Device logic raises interrupts by presenting a vector number on a valid/ready request port. Device logic also declares which vectors it actually uses through increment and decrement strobes on a per-vector use counter.

A request for an unmasked, in-use vector becomes an address/data message on a valid/ready output. A request for a masked vector only sets its pending bit. Any change from masked to unmasked starts a sweep. The change may come from a per-vector mask bit being cleared or from the function mask lifting. The sweep visits every vector, one per clock. For each vector that is pending and now unmasked, it clears the pending bit and sends that vector's message. New requests are held off while a sweep runs or a message waits for acceptance.

A 64-bit software access is split by the bus bridge into two 32-bit accesses, low dword first, in little-endian order. The bridge, configuration decoding and the message fabric sit outside this block.

Top module: `msix_vec_table`

## Requirements
- R1: After reset the control byte reads 0x00, every table address and data dword reads zero, every vector control dword reads 1 (masked), every pending bit is 0, msgValid is 0 and irqReady is 1.
- R2: The table is addressed in dwords; vector v occupies dwords 4v..4v+3 as address low, address high, message data, and vector control, whose bit 0 is the per-vector mask and whose other bits read 0.
- R3: Control byte bit 7 is enable and bit 6 is mask-all; other bits read 0; the function counts as masked when enable is 0 or mask-all is 1.
- R4: A request for an in-range, in-use, effectively unmasked vector produces msgValid with msgAddr = {address high, address low} and msgData = data; these hold stable until msgReady.
- R5: A request whose vector number is NUM_VEC or more, or whose use count is zero, is consumed with no message and no pending bit.
- R6: A request for a vector masked per-vector or by the function mask sets pending bit v and sends nothing; bit v lives at pending dword v/32, bit v%32, which is bit v%8 of byte v/8.
- R7: Clearing a vector's mask bit while the function is unmasked and the vector is pending clears the pending bit and sends that vector's message once.
- R8: A control write that lifts the function mask releases every pending, individually unmasked vector in ascending vector order; vectors still individually masked stay pending.
- R9: Writes to the pending array have no effect; the array spans the vector count rounded up to 64 bits, with bits at and above NUM_VEC reading 0.
- R10: When a vector's use count falls from 1 to 0, its pending bit clears.
- R11: irqReady is 0 while a message is offered or a sweep is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWe | input | 1 | Table dword write strobe |
| tblAddr | input | TA_W | Table dword index |
| tblWdata | input | 32 | Table write data |
| tblRdata | output | 32 | Table read data (combinational from tblAddr) |
| pbaWe | input | 1 | Pending-array write strobe (ignored) |
| pbaAddr | input | PA_W | Pending-array dword index |
| pbaWdata | input | 32 | Pending-array write data (ignored) |
| pbaRdata | output | 32 | Pending-array read data |
| ctlWe | input | 1 | Control byte write strobe |
| ctlWdata | input | 8 | Control byte write data |
| ctlRdata | output | 8 | Control byte read data |
| useInc | input | 1 | Increment use count of useVec |
| useDec | input | 1 | Decrement use count of useVec |
| useVec | input | 11 | Vector for use count update |
| irqValid | input | 1 | Interrupt request valid |
| irqVec | input | 11 | Requested vector number |
| irqReady | output | 1 | Request accepted this cycle |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Message accepted |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |

## Verification
The bench builds the block with NUM_VEC = 40 and USE_W = 4. With 40 vectors the pending array uses both of its dwords, and the second dword is only partly populated, so the zero padding above the vector count can be seen. The ascending sweep runs over a vector count that is not a power of two, and table indices past the last vector can be reached. Request numbers 40 and 63 fall in the gap between the vector count and the width of the index, so they exercise the out-of-range drop.

// File: rtl/msixtbl_pkg.sv
package msixtbl_pkg;
  localparam int VNUM_W = 11;
  localparam int ENABLE_BIT = 7;
  localparam int MASKALL_BIT = 6;

  typedef logic [VNUM_W-1:0] vnum_t;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_VCTRL   = 2'd3
  } entryWord_e;

  // strobes from control to datapath
  typedef struct packed {
    vnum_t sel;
    logic  setPend;
    logic  clrPend;
    logic  loadMsg;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic selMasked;
    logic selPending;
    logic selUsed;
    logic kick;
  } dpStatus_t;

  function automatic int idxW(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int pbaBits(int n);
    return ((n + 63) / 64) * 64;
  endfunction

  function automatic logic vnumOk(vnum_t v, int n);
    return int'(v) < n;
  endfunction
endpackage

// File: rtl/msix_vec_datapath.sv
module msix_vec_datapath
  import msixtbl_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W = 4,
  localparam int VEC_W = idxW(NUM_VEC),
  localparam int TA_W = VEC_W + 2,
  localparam int PBA_BITS = pbaBits(NUM_VEC),
  localparam int PA_W = idxW(PBA_BITS / 32)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tblWe,
  input  logic [TA_W-1:0] tblAddr,
  input  logic [31:0]     tblWdata,
  output logic [31:0]     tblRdata,
  input  logic [PA_W-1:0] pbaAddr,
  output logic [31:0]     pbaRdata,
  input  logic            ctlWe,
  input  logic [7:0]      ctlWdata,
  output logic [7:0]      ctlRdata,
  input  logic            useInc,
  input  logic            useDec,
  input  vnum_t           useVec,
  input  dpStrobe_t       stb,
  output dpStatus_t       stat,
  output logic [63:0]     msgAddr,
  output logic [31:0]     msgData
);
  localparam logic [USE_W-1:0] USE_MAX = '1;

  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] dataW  [NUM_VEC];
  logic [USE_W-1:0] useCnt [NUM_VEC];
  logic [NUM_VEC-1:0] vecMask, pend, pendNext;
  logic enBit, maBit, funcMasked;

  // table address split
  logic [VEC_W-1:0] tVec, selIdx, useIdx;
  entryWord_e tWord;
  logic tOk, useOk, useDrop;
  assign tVec   = tblAddr[TA_W-1:2];
  assign tWord  = entryWord_e'(tblAddr[1:0]);
  assign tOk    = int'(tVec) < NUM_VEC;
  assign selIdx = stb.sel[VEC_W-1:0];
  assign useIdx = useVec[VEC_W-1:0];
  assign useOk  = vnumOk(useVec, NUM_VEC);

  // reads
  always_comb begin
    tblRdata = '0;
    if (tOk) begin
      unique case (tWord)
        W_ADDR_LO: tblRdata = addrLo[tVec];
        W_ADDR_HI: tblRdata = addrHi[tVec];
        W_DATA:    tblRdata = dataW[tVec];
        W_VCTRL:   tblRdata = {31'b0, vecMask[tVec]};
      endcase
    end
  end

  logic [PBA_BITS-1:0] pbaPadded;
  always_comb begin
    pbaPadded = '0;
    pbaPadded[NUM_VEC-1:0] = pend;
  end
  assign pbaRdata = pbaPadded[{pbaAddr, 5'b0} +: 32];
  assign ctlRdata = {enBit, maBit, 6'b0};

  // mask resolution and unmask detection
  logic vecKick, funcKick;
  assign vecKick  = tblWe && tOk && (tWord == W_VCTRL) && vecMask[tVec]
                    && !tblWdata[0] && !funcMasked;
  assign funcKick = ctlWe && funcMasked && ctlWdata[ENABLE_BIT] && !ctlWdata[MASKALL_BIT];

  assign stat.selMasked  = funcMasked | vecMask[selIdx];
  assign stat.selPending = pend[selIdx];
  assign stat.selUsed    = useCnt[selIdx] != '0;
  assign stat.kick       = vecKick | funcKick;

  assign useDrop = useOk && useDec && !useInc && (useCnt[useIdx] == USE_W'(1));

  always_comb begin
    pendNext = pend;
    if (stb.setPend) pendNext[selIdx] = 1'b1;
    if (stb.clrPend) pendNext[selIdx] = 1'b0;
    if (useDrop)     pendNext[useIdx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addrLo[i] <= '0;
        addrHi[i] <= '0;
        dataW[i]  <= '0;
        useCnt[i] <= '0;
      end
      vecMask    <= '1;
      pend       <= '0;
      enBit      <= 1'b0;
      maBit      <= 1'b0;
      funcMasked <= 1'b1;
      msgAddr    <= '0;
      msgData    <= '0;
    end else begin
      pend <= pendNext;
      if (tblWe && tOk) begin
        unique case (tWord)
          W_ADDR_LO: addrLo[tVec]  <= tblWdata;
          W_ADDR_HI: addrHi[tVec]  <= tblWdata;
          W_DATA:    dataW[tVec]   <= tblWdata;
          W_VCTRL:   vecMask[tVec] <= tblWdata[0];
        endcase
      end
      if (ctlWe) begin
        enBit      <= ctlWdata[ENABLE_BIT];
        maBit      <= ctlWdata[MASKALL_BIT];
        funcMasked <= !ctlWdata[ENABLE_BIT] || ctlWdata[MASKALL_BIT];
      end
      if (useOk && useInc && !useDec && useCnt[useIdx] != USE_MAX)
        useCnt[useIdx] <= useCnt[useIdx] + 1'b1;
      else if (useOk && useDec && !useInc && useCnt[useIdx] != '0)
        useCnt[useIdx] <= useCnt[useIdx] - 1'b1;
      if (stb.loadMsg) begin
        msgAddr <= {addrHi[selIdx], addrLo[selIdx]};
        msgData <= dataW[selIdx];
      end
    end
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msixtbl_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqValid,
  input  vnum_t     irqVec,
  output logic      irqReady,
  output logic      msgValid,
  input  logic      msgReady,
  input  dpStatus_t stat,
  output dpStrobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_SEND} state_e;

  state_e state;
  vnum_t  ptr;
  logic   retSweep, sweepReq;
  logic   irqOk, sweepHit, lastPtr;

  assign irqReady = (state == S_IDLE) && !sweepReq;
  assign msgValid = (state == S_SEND);
  assign irqOk    = irqValid && irqReady && vnumOk(irqVec, NUM_VEC) && stat.selUsed;
  assign sweepHit = (state == S_SWEEP) && stat.selPending && !stat.selMasked;
  assign lastPtr  = int'(ptr) == NUM_VEC - 1;

  always_comb begin
    stb = '0;
    stb.sel = (state == S_SWEEP) ? ptr : irqVec;
    if (irqOk) begin
      stb.setPend = stat.selMasked;
      stb.loadMsg = !stat.selMasked;
    end
    if (sweepHit) begin
      stb.clrPend = 1'b1;
      stb.loadMsg = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      ptr      <= '0;
      retSweep <= 1'b0;
      sweepReq <= 1'b0;
    end else begin
      sweepReq <= stat.kick || (sweepReq && state != S_IDLE);
      unique case (state)
        S_IDLE: begin
          if (sweepReq) begin
            state <= S_SWEEP;
            ptr   <= '0;
          end else if (irqOk && !stat.selMasked) begin
            state    <= S_SEND;
            retSweep <= 1'b0;
          end
        end
        S_SWEEP: begin
          ptr <= ptr + 1'b1;
          if (sweepHit) begin
            state    <= S_SEND;
            retSweep <= !lastPtr;
          end else if (lastPtr) begin
            state <= S_IDLE;
          end
        end
        S_SEND: begin
          if (msgReady) state <= retSweep ? S_SWEEP : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msixtbl_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W = 4,
  localparam int TA_W = idxW(NUM_VEC) + 2,
  localparam int PA_W = idxW(pbaBits(NUM_VEC) / 32)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tblWe,
  input  logic [TA_W-1:0] tblAddr,
  input  logic [31:0]     tblWdata,
  output logic [31:0]     tblRdata,
  input  logic            pbaWe,
  input  logic [PA_W-1:0] pbaAddr,
  input  logic [31:0]     pbaWdata,
  output logic [31:0]     pbaRdata,
  input  logic            ctlWe,
  input  logic [7:0]      ctlWdata,
  output logic [7:0]      ctlRdata,
  input  logic            useInc,
  input  logic            useDec,
  input  logic [10:0]     useVec,
  input  logic            irqValid,
  input  logic [10:0]     irqVec,
  output logic            irqReady,
  output logic            msgValid,
  input  logic            msgReady,
  output logic [63:0]     msgAddr,
  output logic [31:0]     msgData
);
  dpStrobe_t stb;
  dpStatus_t stat;

  // the pending array is read-only from the bus (R9)
  logic unusedPbaWrite;
  assign unusedPbaWrite = ^{pbaWe, pbaWdata};

  msix_vec_datapath #(.NUM_VEC(NUM_VEC), .USE_W(USE_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblWdata(tblWdata), .tblRdata(tblRdata),
    .pbaAddr(pbaAddr), .pbaRdata(pbaRdata),
    .ctlWe(ctlWe), .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .useInc(useInc), .useDec(useDec), .useVec(useVec),
    .stb(stb), .stat(stat), .msgAddr(msgAddr), .msgData(msgData)
  );

  msix_vec_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .irqValid(irqValid), .irqVec(irqVec), .irqReady(irqReady),
    .msgValid(msgValid), .msgReady(msgReady),
    .stat(stat), .stb(stb)
  );
endmodule

// File: rtl/msix_vec_table_chk.sv
module msix_vec_table_chk #(
  parameter int NUM_VEC = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  ctlRdata,
  input logic        irqValid,
  input logic [10:0] irqVec,
  input logic        irqReady,
  input logic        msgValid,
  input logic        msgReady,
  input logic [63:0] msgAddr,
  input logic [31:0] msgData
);
  // R4: an offered message holds until taken
  a_r4_msg_hold: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));

  // R4: an accepted message is not offered again in the next cycle
  a_r4_msg_gap: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid);

  // R11: no request accepted while a message is offered
  a_r11_stall: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !irqReady);

  // R5: out-of-range request produces no message
  a_r5_range_drop: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqReady && (int'(irqVec) >= NUM_VEC) |=> !msgValid);

  // R6: request under a function mask produces no message
  a_r6_func_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqReady && (!ctlRdata[7] || ctlRdata[6]) |=> !msgValid);
endmodule

bind msix_vec_table msix_vec_table_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rstN(rstN), .ctlRdata(ctlRdata),
  .irqValid(irqValid), .irqVec(irqVec), .irqReady(irqReady),
  .msgValid(msgValid), .msgReady(msgReady),
  .msgAddr(msgAddr), .msgData(msgData)
);

// File: tb/msix_vec_table_test.sv
module msix_vec_table_test;
  localparam int NV = 40;
  localparam int TA_W = 8;
  localparam int PA_W = 1;

  logic clk = 0, rstN = 0;
  logic tblWe = 0, pbaWe = 0, ctlWe = 0, useInc = 0, useDec = 0;
  logic irqValid = 0, msgReady = 0;
  logic [TA_W-1:0] tblAddr = '0;
  logic [PA_W-1:0] pbaAddr = '0;
  logic [31:0] tblWdata = '0, pbaWdata = '0, tblRdata, pbaRdata, msgData;
  logic [7:0] ctlWdata = '0, ctlRdata;
  logic [10:0] useVec = '0, irqVec = '0;
  logic irqReady, msgValid;
  logic [63:0] msgAddr;
  int nChecks = 0, nErr = 0;

  always #2 clk = ~clk;

  msix_vec_table #(.NUM_VEC(NV), .USE_W(4)) uut (.*);

  typedef struct packed { logic [10:0] vec; logic msg; logic pend; logic pbaChk; } case_t;
  localparam case_t CASES [7] = '{
    '{11'd2,  1'b1, 1'b0, 1'b1},
    '{11'd39, 1'b1, 1'b0, 1'b1},
    '{11'd7,  1'b0, 1'b1, 1'b1},
    '{11'd5,  1'b0, 1'b0, 1'b1},
    '{11'd40, 1'b0, 1'b0, 1'b0},
    '{11'd63, 1'b0, 1'b0, 1'b0},
    '{11'd33, 1'b0, 1'b1, 1'b1}
  };

  function automatic logic [63:0] eAddr(int v);
    return {32'hA000_0000 | 32'(v), 32'h1000_0000 + 32'(v * 16)};
  endfunction
  function automatic logic [31:0] eData(int v);
    return 32'hD000_0000 + 32'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic wrTbl(input int a, input logic [31:0] d);
    tblAddr = TA_W'(a); tblWdata = d; tblWe = 1; tick; tblWe = 0;
  endtask
  task automatic rdTbl(input int a, output logic [31:0] d);
    tblAddr = TA_W'(a); #1 d = tblRdata;
  endtask
  task automatic ctlWr(input logic [7:0] d);
    ctlWdata = d; ctlWe = 1; tick; ctlWe = 0;
  endtask
  task automatic useOp(input int v, input bit inc);
    useVec = 11'(v); useInc = inc; useDec = !inc; tick; useInc = 0; useDec = 0;
  endtask
  task automatic pendBit(input int v, output logic b);
    pbaAddr = PA_W'(v / 32); #1 b = pbaRdata[v % 32];
  endtask
  task automatic doIrq(input int v);
    irqVec = 11'(v); irqValid = 1;
    for (int i = 0; i < 300 && !irqReady; i++) tick;
    tick; irqValid = 0;
  endtask
  task automatic getMsg(input int v, input string tag);
    for (int i = 0; i < 300 && !msgValid; i++) tick;
    chk(msgValid, {tag, " valid"}, 64'(msgValid), 64'd1);
    chk(msgAddr == eAddr(v), {tag, " addr"}, msgAddr, eAddr(v));
    chk(msgData == eData(v), {tag, " data"}, 64'(msgData), 64'(eData(v)));
    msgReady = 1; tick; msgReady = 0;
  endtask
  task automatic noMsg(input string tag);
    logic seen = 0;
    for (int i = 0; i < 4; i++) begin seen |= msgValid; tick; end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  task automatic checkReset(input string tag);
    logic [31:0] d; logic b;
    #1 chk(ctlRdata == 8'h00, {tag, " R1 ctl"}, 64'(ctlRdata), 0);
    chk(!msgValid && irqReady, {tag, " R1 handshake"}, {62'd0, msgValid, irqReady}, 64'd1);
    rdTbl(4 * 2, d);     chk(d == 0, {tag, " R1 addr lo"}, 64'(d), 0);
    rdTbl(4 * 2 + 2, d); chk(d == 0, {tag, " R1 data"}, 64'(d), 0);
    rdTbl(4 * 39 + 3, d); chk(d == 1, {tag, " R1 mask"}, 64'(d), 1);
    pbaAddr = 0; #1 chk(pbaRdata == 0, {tag, " R1 pba0"}, 64'(pbaRdata), 0);
    pbaAddr = 1; #1 chk(pbaRdata == 0, {tag, " R1 pba1"}, 64'(pbaRdata), 0);
    pendBit(2, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [31:0] d; logic b;
    repeat (3) @(negedge clk);
    rstN = 1; tick;
    checkReset("reset");

    // program all entries, declare use except vector 5
    for (int v = 0; v < NV; v++) begin
      wrTbl(4 * v, eAddr(v)[31:0]);
      wrTbl(4 * v + 1, eAddr(v)[63:32]);
      wrTbl(4 * v + 2, eData(v));
      if (v != 5) useOp(v, 1);
    end
    rdTbl(4 * 17 + 1, d); chk(d == eAddr(17)[63:32], "R2 addr hi readback", 64'(d), 64'(eAddr(17)[63:32]));
    rdTbl(4 * 17 + 2, d); chk(d == eData(17), "R2 data readback", 64'(d), 64'(eData(17)));
    ctlWr(8'h80);
    chk(ctlRdata == 8'h80, "R3 enable readback", 64'(ctlRdata), 64'h80);
    for (int v = 0; v < NV; v++) if (v != 7 && v != 33) wrTbl(4 * v + 3, 32'hFFFF_FFFE);
    rdTbl(4 * 8 + 3, d); chk(d == 0, "R2 vctrl reserved bits read 0", 64'(d), 0);
    rdTbl(4 * 7 + 3, d); chk(d == 1, "R2 vctrl mask still set", 64'(d), 1);

    // table-driven requests (R4 R5 R6)
    foreach (CASES[i]) begin
      doIrq(int'(CASES[i].vec));
      if (CASES[i].msg) getMsg(int'(CASES[i].vec), $sformatf("R4 irq %0d", CASES[i].vec));
      else noMsg($sformatf("R5/R6 no message for irq %0d", CASES[i].vec));
      if (CASES[i].pbaChk) begin
        pendBit(int'(CASES[i].vec), b);
        chk(b == CASES[i].pend, $sformatf("R6 pending bit %0d", CASES[i].vec), 64'(b), 64'(CASES[i].pend));
      end
    end

    // R7 per-vector unmask releases pending
    wrTbl(4 * 7 + 3, 0);
    getMsg(7, "R7 release vec 7");
    pendBit(7, b); chk(b == 0, "R7 pending cleared", 64'(b), 0);
    noMsg("R7 single release");

    // R8 function unmask sweep in ascending order
    ctlWr(8'hC0);
    doIrq(20); doIrq(2); doIrq(10);
    noMsg("R6 mask-all blocks messages");
    pendBit(20, b); chk(b == 1, "R6 pending 20 under mask-all", 64'(b), 1);
    ctlWr(8'h80);
    for (int i = 0; i < 300 && !msgValid; i++) tick;
    chk(!irqReady, "R11 irqReady low while offered", 64'(irqReady), 0);
    getMsg(2, "R8 first");
    getMsg(10, "R8 second");
    getMsg(20, "R8 third");
    noMsg("R8 masked vector not released");
    pendBit(33, b); chk(b == 1, "R8 vec 33 still pending", 64'(b), 1);

    // R9 pending array writes ignored, tail zero
    pbaAddr = 0; pbaWdata = '1; pbaWe = 1; tick; pbaWe = 0;
    #1 chk(pbaRdata == 0, "R9 pba write ignored dword0", 64'(pbaRdata), 0);
    pbaAddr = 1; #1 chk(pbaRdata == 32'h2, "R9 pba dword1", 64'(pbaRdata), 64'h2);

    // R10 use count drop clears pending
    useOp(33, 0);
    pendBit(33, b); chk(b == 0, "R10 pending cleared on unuse", 64'(b), 0);

    // R3 enable clear masks the function
    ctlWr(8'hFF);
    chk(ctlRdata == 8'hC0, "R3 reserved control bits", 64'(ctlRdata), 64'hC0);
    ctlWr(8'h40);
    doIrq(2);
    noMsg("R3 enable clear masks");
    pendBit(2, b); chk(b == 1, "R3 pending with enable clear", 64'(b), 1);
    ctlWr(8'h80);
    getMsg(2, "R3 release on enable");

    // R1 reset in the middle of operation
    doIrq(7);
    rstN = 0; tick; rstN = 1; tick;
    checkReset("R1 second reset");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule